// File: doc/BRIEF.md
# Multi-Channel Match-Based PWM Timer

This block generates up to six pulse-width-modulated outputs from one shared timebase. A prescaler divides the clock, and the timer counter advances by one each time the prescaler wraps. Seven match values are compared against the counter. Match 0 normally sets the period. Matches 1 to 6 place the edges of the outputs.

Each match has its own controls. A match can return the counter to zero, halt the counter and prescaler, or raise an interrupt flag. Each output can be driven in one of two ways. In single-edge mode it rises at the period rollover. In double-edge mode it rises at the previous match. Software writes new match values into shadow copies. It marks which shadows should take effect, and the hardware copies them into the active comparators at the next rollover. This keeps the period and duty cycle consistent within each period.

All configuration goes through a plain register port. The port has a one-cycle write strobe and a combinational read.

Top module: `pwm_match_timer`

## Requirements
- R1: While reset is asserted, the counter (read at word 2), the prescale count (word 4) and the flag word (word 0) read zero, and `pwm_o` and `irq_o` are low.
- R2: Control word 1 holds the run bit in bit 0. While running, the prescale count steps from 0 up to the limit in word 3 and then wraps, and the counter advances exactly once on each wrap. While stopped, both counts hold their values.
- R3: Bit 1 of control word 1 holds the counter and the prescale count at zero for as long as it is set.
- R4: Match k fires in the cycle where the prescaler wraps while the counter equals the active value k. Word 5 holds three bits per match, starting at bit 3k: bit 3k enables the interrupt, bit 3k+1 resets the counter and bit 3k+2 stops it. A reset-enabled match returns the counter to 0, so the period is (M0+1)(P+1) cycles.
- R5: When a match with its stop bit set fires, the counter keeps its value, the prescale count returns to 0, and the run bit reads 0.
- R6: A match with its interrupt bit set raises its flag. Flags 0-3 read at bits 0-3 of word 0 and flags 4-6 at bits 8-10. All other bits read zero. `irq_o` is high while any flag is set.
- R7: Writing a 1 to a flag bit in word 0 clears that flag, and writing a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: Writes to words 8-14 (match 0-6) land in shadow copies, which read back at once but do not affect matching. Bit k of word 7 marks shadow k as pending. At a rollover (match 0 with its reset bit set), every pending shadow becomes active and word 7 clears.
- R9: For a single-edge output k, the output rises at the rollover and falls when match k fires.
- R10: Bit k of word 6 selects double-edge mode for output k, for k from 2 to 6. In that mode the output rises when match k-1 fires and falls when match k fires. If both happen in the same cycle, the output falls. Bit 1 of word 6 is ignored.
- R11: Output 6 falls when match 6 fires, in either mode.
- R12: Bit 8+k of word 6 enables output k. A disabled output reads low on `pwm_o[k-1]`, and its internal edges keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | 32 | Register read data, combinational |
| pwm_o | output | 6 | Outputs 1 to 6, with bit k-1 carrying output k |
| irq_o | output | 1 | High while any interrupt flag is set |

## Verification
Two events can land in the same cycle. A match can set an interrupt flag while a write-one-to-clear hits that flag. Separately, in double-edge mode, the rising match and the falling match of one output can coincide. The bench provokes the first case by holding a clear-all write on the flag word for several whole periods, so that match events arrive while the clear is active. It provokes the second by programming two adjacent matches to the same value. A cycle-level model predicts `irq_o`, `pwm_o` and the register reads, and the scoreboard compares these every cycle. A flag that was dropped, or an output pulse that should not appear, is therefore reported in the cycle it happens.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NUM_MATCH = 7;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 32;

  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd0;
  localparam logic [ADDR_W-1:0] A_TCR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_TC    = 4'd2;
  localparam logic [ADDR_W-1:0] A_PLIM  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PC    = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCR   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CTL   = 4'd6;
  localparam logic [ADDR_W-1:0] A_LE    = 4'd7;
  localparam logic [ADDR_W-1:0] A_MR0   = 4'd8;

  localparam int unsigned OEN_LSB = 8;

  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } mctl_t;

  // flag bit position inside the flag word
  function automatic int unsigned flag_pos(int unsigned n);
    return (n < 4) ? n : n + 4;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             cnt_clr_i,
  input  logic             cnt_stop_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] pc_o,
  output logic [CNT_W-1:0] tc_o
);
  logic active;

  assign active = run_i & ~hold_i;
  assign tick_o = active && (pc_o == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o <= '0;
      tc_o <= '0;
    end else if (hold_i) begin
      pc_o <= '0;
      tc_o <= '0;
    end else begin
      if (active) pc_o <= tick_o ? '0 : pc_o + CNT_W'(1);
      if (tick_o) begin
        if (cnt_clr_i)       tc_o <= '0;
        else if (!cnt_stop_i) tc_o <= tc_o + CNT_W'(1);
      end
    end
  end

  // R3
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (pc_o == '0 && tc_o == '0)) else $error("hold_zero_chk");
  // R2
  tc_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !hold_i) |=> $stable(tc_o)) else $error("tc_steady_chk");
  // R2
  pc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_i) |=> $stable(pc_o)) else $error("pc_idle_chk");
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int unsigned N     = 7,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sh_we_i,
  input  logic [IDX_W-1:0]        sh_idx_i,
  input  logic [CNT_W-1:0]        sh_data_i,
  input  logic                    le_we_i,
  input  logic [N-1:0]            le_data_i,
  input  logic                    tick_i,
  input  logic [CNT_W-1:0]        tc_i,
  input  logic                    p0_reset_i,
  output logic [N-1:0]            hit_o,
  output logic                    rollover_o,
  output logic [N-1:0]            le_o,
  output logic [N-1:0][CNT_W-1:0] shadow_o
);
  logic [N-1:0][CNT_W-1:0] act_q;

  assign rollover_o = hit_o[0] & p0_reset_i;

  for (genvar n = 0; n < N; n++) begin : g_m
    assign hit_o[n] = tick_i && (tc_i == act_q[n]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_o[n] <= '0;
        act_q[n]    <= '0;
      end else begin
        if (sh_we_i && sh_idx_i == IDX_W'(n)) shadow_o[n] <= sh_data_i;
        if (rollover_o && le_o[n])            act_q[n]    <= shadow_o[n];
      end
    end

    // R8
    latch_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rollover_o && le_o[n]) |=> act_q[n] == $past(shadow_o[n])) else $error("latch_take_chk");
    // R8
    act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rollover_o |=> $stable(act_q[n])) else $error("act_hold_chk");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         le_o <= '0;
    else if (rollover_o) le_o <= '0;
    else if (le_we_i)    le_o <= le_data_i;
  end

  // R8
  le_selfclear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |=> le_o == '0) else $error("le_selfclear_chk");
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  // R10
  clr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o) else $error("clr_first_chk");
  // R9
  set_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o) else $error("set_edge_chk");
endmodule

// File: rtl/pwm_irq_flags.sv
module pwm_irq_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] raise;

  assign raise = hit_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | raise;
  end

  for (genvar n = 0; n < N; n++) begin : g_chk
    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise[n] |=> flags_o[n]) else $error("set_wins_chk");
    // R7
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !raise[n]) |=> !flags_o[n]) else $error("w1c_chk");
    // R7
    keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[n] && flags_o[n]) |=> flags_o[n]) else $error("keep_chk");
  end
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NUM_MATCH-2:0]   pwm_o,
  output logic                   irq_o
);
  localparam int unsigned N     = NUM_MATCH;
  localparam int unsigned IDX_W = $clog2(N);

  mctl_t [N-1:0]           mcr_q;
  logic                    run_q, hold_q;
  logic [CNT_W-1:0]        plim_q, pc, tc;
  logic [N-1:0]            sel_q, oen_q, hit, le, flags, flag_clr;
  logic [N-1:0]            irq_en, rst_en, stop_en;
  logic [N-1:0][CNT_W-1:0] shadow;
  logic                    tick, rollover, cnt_clr, cnt_stop;
  logic [ADDR_W-1:0]       wr_off, rd_off;
  logic                    sh_we, le_we;

  assign wr_off = wr_addr_i - A_MR0;
  assign rd_off = rd_addr_i - A_MR0;
  assign sh_we  = wr_en_i && (wr_addr_i >= A_MR0) && (wr_off < ADDR_W'(N));
  assign le_we  = wr_en_i && (wr_addr_i == A_LE);

  for (genvar n = 0; n < N; n++) begin : g_dec
    assign irq_en[n]   = mcr_q[n].irq;
    assign rst_en[n]   = mcr_q[n].rst;
    assign stop_en[n]  = mcr_q[n].stop;
    assign flag_clr[n] = wr_en_i && (wr_addr_i == A_FLAGS) && wr_data_i[flag_pos(n)];
  end

  assign cnt_clr  = |(hit & rst_en);
  assign cnt_stop = |(hit & stop_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      plim_q <= '0;
      mcr_q  <= '0;
      sel_q  <= '0;
      oen_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_TCR) begin
        run_q  <= wr_data_i[0];
        hold_q <= wr_data_i[1];
      end
      if (cnt_stop) run_q <= 1'b0;
      if (wr_en_i && wr_addr_i == A_PLIM) plim_q <= wr_data_i[CNT_W-1:0];
      if (wr_en_i && wr_addr_i == A_MCR)  mcr_q  <= wr_data_i[3*N-1:0];
      if (wr_en_i && wr_addr_i == A_CTL) begin
        sel_q <= wr_data_i[N-1:0];
        oen_q <= wr_data_i[OEN_LSB+:N];
      end
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .hold_i     (hold_q),
    .cnt_clr_i  (cnt_clr),
    .cnt_stop_i (cnt_stop),
    .limit_i    (plim_q),
    .tick_o     (tick),
    .pc_o       (pc),
    .tc_o       (tc)
  );

  pwm_match_bank #(.N(N), .CNT_W(CNT_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sh_we_i    (sh_we),
    .sh_idx_i   (wr_off[IDX_W-1:0]),
    .sh_data_i  (wr_data_i[CNT_W-1:0]),
    .le_we_i    (le_we),
    .le_data_i  (wr_data_i[N-1:0]),
    .tick_i     (tick),
    .tc_i       (tc),
    .p0_reset_i (rst_en[0]),
    .hit_o      (hit),
    .rollover_o (rollover),
    .le_o       (le),
    .shadow_o   (shadow)
  );

  for (genvar c = 1; c < N; c++) begin : g_ch
    logic set, q;
    if (c >= 2) begin : g_dbl
      assign set = sel_q[c] ? hit[c-1] : rollover;
    end else begin : g_sgl
      assign set = rollover;
    end
    pwm_out_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set),
      .clr_i  (hit[c]),
      .q_o    (q)
    );
    assign pwm_o[c-1] = q & oen_q[c];
  end

  pwm_irq_flags #(.N(N)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .en_i    (irq_en),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  assign irq_o = |flags;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_FLAGS: for (int n = 0; n < N; n++) rd_data_o[flag_pos(n)] = flags[n];
      A_TCR:   rd_data_o[1:0] = {hold_q, run_q};
      A_TC:    rd_data_o[CNT_W-1:0] = tc;
      A_PLIM:  rd_data_o[CNT_W-1:0] = plim_q;
      A_PC:    rd_data_o[CNT_W-1:0] = pc;
      A_MCR:   rd_data_o[3*N-1:0] = mcr_q;
      A_CTL: begin
        rd_data_o[N-1:0]        = sel_q;
        rd_data_o[OEN_LSB+:N]   = oen_q;
      end
      A_LE:    rd_data_o[N-1:0] = le;
      default: if (rd_off < ADDR_W'(N)) rd_data_o[CNT_W-1:0] = shadow[rd_off[IDX_W-1:0]];
    endcase
  end

  // R5
  stop_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_stop |=> !run_q) else $error("stop_run_chk");
  // R5
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_stop && !cnt_clr && !hold_q) |=> tc == $past(tc)) else $error("stop_freeze_chk");
  // R4
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr && !hold_q) |=> tc == '0) else $error("period_wrap_chk");
endmodule

// File: tb/pwm_match_timer_tb.sv
module pwm_match_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  pwm_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pwm_match_timer u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .pwm_o     (pwm_o),
    .irq_o     (irq_o)
  );

  typedef struct packed { logic [5:0] pwm; logic irq; } exp_t;
  exp_t exp_q[$];

  // reference model state
  logic [31:0] m_pc = '0, m_tc = '0, m_plim = '0;
  logic        m_run = 1'b0, m_hold = 1'b0;
  logic [20:0] m_mcr = '0;
  logic [6:0]  m_sel = '0, m_oen = '0, m_le = '0, m_q = '0, m_f = '0;
  logic [31:0] m_sh [7];
  logic [31:0] m_act [7];

  function automatic int fpos(int n);
    return (n < 4) ? n : n + 4;
  endfunction

  initial for (int n = 0; n < 7; n++) begin m_sh[n] = '0; m_act[n] = '0; end

  // driver side: advance model, push expected outputs
  always @(posedge clk_i) begin : model
    logic run, tick, roll, rst_any, stop_any, set;
    logic [6:0] hit, clrm, irqm, nq, nle;
    logic [31:0] ntc, npc;
    if (rst_ni) begin
      run  = m_run && !m_hold;
      tick = run && (m_pc == m_plim);
      rst_any = 1'b0; stop_any = 1'b0;
      for (int n = 0; n < 7; n++) begin
        hit[n]   = tick && (m_tc == m_act[n]);
        irqm[n]  = m_mcr[3*n];
        rst_any  = rst_any  | (hit[n] & m_mcr[3*n+1]);
        stop_any = stop_any | (hit[n] & m_mcr[3*n+2]);
      end
      roll = hit[0] && m_mcr[1];
      if (m_hold) begin npc = '0; ntc = '0; end
      else begin
        npc = run ? (tick ? 32'd0 : m_pc + 1) : m_pc;
        ntc = m_tc;
        if (tick) begin
          if (rst_any) ntc = '0;
          else if (!stop_any) ntc = m_tc + 1;
        end
      end
      nq = m_q;
      for (int c = 1; c < 7; c++) begin
        set = (c >= 2 && m_sel[c]) ? hit[c-1] : roll;
        if (hit[c]) nq[c] = 1'b0;
        else if (set) nq[c] = 1'b1;
      end
      if (roll) for (int n = 0; n < 7; n++) if (m_le[n]) m_act[n] = m_sh[n];
      clrm = '0;
      if (wr_en && wr_addr == 4'd0) for (int n = 0; n < 7; n++) clrm[n] = wr_data[fpos(n)];
      m_f = (m_f & ~clrm) | (hit & irqm);
      nle = roll ? 7'd0 : ((wr_en && wr_addr == 4'd7) ? wr_data[6:0] : m_le);
      if (wr_en) begin
        case (wr_addr)
          4'd1: begin m_run = wr_data[0]; m_hold = wr_data[1]; end
          4'd3: m_plim = wr_data;
          4'd5: m_mcr = wr_data[20:0];
          4'd6: begin m_sel = wr_data[6:0]; m_oen = wr_data[14:8]; end
          default: if (wr_addr >= 4'd8 && wr_addr <= 4'd14) m_sh[wr_addr-8] = wr_data;
        endcase
      end
      if (stop_any) m_run = 1'b0;
      m_le = nle; m_pc = npc; m_tc = ntc; m_q = nq;
      exp_q.push_back('{pwm: m_q[6:1] & m_oen[6:1], irq: |m_f});
    end
  end

  // monitor side: pop and compare
  always @(negedge clk_i) begin
    exp_t e;
    if (rst_ni && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (pwm_o !== e.pwm) begin
        errors++;
        $display("FAIL pwm R9 R10 R11 R12 act %h exp %h t=%0t", pwm_o, e.pwm, $time);
      end
      checks++;
      if (irq_o !== e.irq) begin
        errors++;
        $display("FAIL irq R6 R7 act %0b exp %0b t=%0t", irq_o, e.irq, $time);
      end
    end
  end

  function automatic logic [31:0] mread(logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'd0: for (int n = 0; n < 7; n++) r[fpos(n)] = m_f[n];
      4'd1: r[1:0] = {m_hold, m_run};
      4'd2: r = m_tc;
      4'd3: r = m_plim;
      4'd4: r = m_pc;
      4'd5: r[20:0] = m_mcr;
      4'd6: begin r[6:0] = m_sel; r[14:8] = m_oen; end
      4'd7: r[6:0] = m_le;
      default: if (a <= 4'd14) r = m_sh[a-8];
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_i);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    @(negedge clk_i);
    rd_addr = a;
    #1;
    chk(tag, rd_data, mread(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 pwm", 32'(pwm_o), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    rd_addr = 4'd2; #1; chk("R1 tc", rd_data, 32'd0);
    rd_addr = 4'd4; #1; chk("R1 pc", rd_data, 32'd0);
    rd_addr = 4'd0; #1; chk("R1 flags", rd_data, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    wr(4'd3, 32'd1);
    wr(4'd8, 32'd9);   // period
    wr(4'd9, 32'd3);
    wr(4'd10, 32'd2);
    wr(4'd11, 32'd5);
    wr(4'd12, 32'd7);
    wr(4'd13, 32'd6);
    wr(4'd14, 32'd8);  // R11: match 6 ends output 6 before period end
    wr(4'd5, 32'h4000B);
    wr(4'd6, 32'h6E00 | 32'h2A);  // R10 ch3/ch5 double, ch1 select ignored; R12 ch4 off
    wr(4'd7, 32'h7F);
    rd_chk(4'd7, "R8 pending");
    rd_chk(4'd9, "R8 shadow");
    wr(4'd1, 32'd1);
    for (int i = 0; i < 12; i++) begin
      idle(5);
      rd_chk(4'd2, "R2 R4 tc");
      rd_chk(4'd4, "R2 pc");
    end

    // R7: clear-all held across match events
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hFFFF_FFFF;
    idle(60);
    wr_en = 1'b0;
    idle(30);
    rd_chk(4'd0, "R6 flags");
    rd_addr = 4'd0; #1;
    chk("R6 reserved", rd_data & ~32'h0000_070F, 32'd0);
    wr(4'd0, 32'd0);
    rd_chk(4'd0, "R7 zero write");
    wr(4'd0, 32'h0402);
    rd_chk(4'd0, "R7 partial clear");

    // R8: shadow without pending bit
    wr(4'd9, 32'd5);
    idle(45);
    rd_chk(4'd9, "R8 shadow readback");
    wr(4'd7, 32'h02);
    rd_chk(4'd7, "R8 pending set");
    idle(45);
    rd_chk(4'd7, "R8 selfclear");

    // R2: no prescale
    wr(4'd3, 32'd0);
    idle(40);
    rd_chk(4'd2, "R2 tc fast");

    // R3: hold
    wr(4'd1, 32'd3);
    idle(4);
    rd_chk(4'd2, "R3 tc");
    rd_chk(4'd4, "R3 pc");
    chk("R3 zero", rd_data, 32'd0);
    wr(4'd1, 32'd1);
    idle(20);

    // R10: rise and fall on same match, fall wins
    wr(4'd9, 32'd4);
    wr(4'd10, 32'd4);
    wr(4'd7, 32'h06);
    wr(4'd6, 32'h6E00 | 32'h2E);
    idle(60);

    // R5: stop on match 4 (value 7)
    wr(4'd5, 32'h4000B | 32'h4000);
    idle(40);
    rd_chk(4'd1, "R5 run bit");
    rd_chk(4'd2, "R5 tc");
    chk("R5 tc value", rd_data, 32'd7);
    wr(4'd5, 32'h4000B);
    wr(4'd1, 32'd1);
    idle(40);
    rd_chk(4'd2, "R4 restart");

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule